// File: doc/BRIEF.md
# Dual-Port Cache Data SRAM

A synchronous cache data memory, one word of eight data bits plus a parity bit wide, with two data ports. The primary port faces the processor and the secondary port faces main memory. Each port has its own input enable and output enable. Both ports share one address bus, one write strobe and a pair of chip selects. The port pins are split into an input word, an output word and a drive enable, so the pad ring or bus fabric can resolve the tristate.

On every rising clock edge the block samples all controls, the address and both input words. It decodes them into one operation:
- a read to one port or to both;
- a write from either port;
- a write that also forwards the incoming word to the opposite port;
- a pass-through from one port to the other that leaves the array untouched;
- no operation.

Results appear on the outputs right after that same edge. A parity-check flag follows one edge later. A separate flag reports control combinations that would have a port drive and receive at once.

The depth is 2**ADDR_W words. Set ADDR_W to 15 for a 32K-word array.

Top module: `cache_dsram`

## Requirements
- R1: The block is selected only when cs1_n is 0 and cs2 is 1. A deselected cycle drives neither port (pd_oe = sd_oe = 0), writes nothing, and returns par_ok to 1 at the next edge.
- R2: With wr_n=1, pie_n=1 and sie_n=1, the addressed array word is read. poe_n=0 drives it on pd_out and soe_n=0 drives it on sd_out. Both may be low together. Both high drives nothing.
- R3: wr_n=0, pie_n=0, sie_n=1, poe_n=1, soe_n=1 stores pd_in at addr. wr_n=0, sie_n=0, pie_n=1, poe_n=1, soe_n=1 stores sd_in at addr. Neither drives a port.
- R4: With wr_n=0, pie_n=0, sie_n=1, soe_n=0, poe_n=1, pd_in is stored and also driven on sd_out. The mirror case stores sd_in and drives it on pd_out.
- R5: With wr_n=1 and one port's input enable low, the other port's output enable low, and the first port's output enable high, the input word is driven on the other port's output. The array is not written.
- R6: Both input enables low, or wr_n=0 with both input enables high, performs no operation: no write, no drive.
- R7: A port whose input enable is sampled low never drives, whatever its output enable is.
- R8: par_ok is bit 8 of the port word taken as parity, odd over all 9 bits. After a read, par_ok is loaded at the following edge: 1 if the word read holds an odd number of ones, 0 otherwise. After every cycle that is not a read, par_ok is 1.
- R9: bad_combo is 1 after an edge that sampled a selected cycle where one port's input enable and output enable are both low while the other port's input enable is high. That cycle writes nothing and drives neither port.
- R10: Every operation's drive enables and data appear right after the edge that sampled it. After reset, pd_oe=0, sd_oe=0, bad_combo=0 and par_ok=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Word address |
| wr_n | input | 1 | Write strobe, active low |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| pie_n | input | 1 | Primary input enable, active low |
| sie_n | input | 1 | Secondary input enable, active low |
| poe_n | input | 1 | Primary output enable, active low |
| soe_n | input | 1 | Secondary output enable, active low |
| pd_in | input | DATA_W+1 | Primary input word, parity in the top bit |
| pd_out | output | DATA_W+1 | Primary output latch |
| pd_oe | output | 1 | Primary drive enable |
| sd_in | input | DATA_W+1 | Secondary input word, parity in the top bit |
| sd_out | output | DATA_W+1 | Secondary output latch |
| sd_oe | output | 1 | Secondary drive enable |
| par_ok | output | 1 | Parity check of the previous read, 1 when good |
| bad_combo | output | 1 | Contention combination was sampled |

## Verification
A read and its parity check fall in different cycles. The result of a read at one edge is judged at the next edge, in the same cycle as whatever operation comes after it. The bench places back-to-back reads of good-parity and bad-parity words, and reads followed by writes, deselects and contention cycles. A behavioural model predicts par_ok from the word it stored, using the chip select of the following cycle. Streaming writes that also update the array are judged by the forwarded word on the opposite port in the same cycle, and by a later read of the array.

// File: rtl/cache_dsram.sv
module cache_dsram #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_n,
  input  logic              cs1_n,
  input  logic              cs2,
  input  logic              pie_n,
  input  logic              sie_n,
  input  logic              poe_n,
  input  logic              soe_n,
  input  logic [DATA_W:0]   pd_in,
  output logic [DATA_W:0]   pd_out,
  output logic              pd_oe,
  input  logic [DATA_W:0]   sd_in,
  output logic [DATA_W:0]   sd_out,
  output logic              sd_oe,
  output logic              par_ok,
  output logic              bad_combo
);
  localparam int WORD_W = DATA_W + 1;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] rd_word;
  logic              rd_pend;

  wire sel  = !cs1_n && cs2;
  wire p_in = !pie_n;
  wire s_in = !sie_n;
  wire bad  = sel && ((p_in && !s_in && !poe_n) || (s_in && !p_in && !soe_n));
  wire ok   = sel && !bad;

  wire rd     = ok && wr_n && !p_in && !s_in;
  wire rd_p   = rd && !poe_n;
  wire rd_s   = rd && !soe_n;
  wire from_p = ok && p_in && !s_in;
  wire from_s = ok && s_in && !p_in;
  wire wr_p   = from_p && !wr_n;
  wire wr_s   = from_s && !wr_n;
  wire st_s   = from_p && !soe_n;
  wire st_p   = from_s && !poe_n;

  always_ff @(posedge clk) begin
    if (wr_p)      mem[addr] <= pd_in;
    else if (wr_s) mem[addr] <= sd_in;
  end

  always_ff @(posedge clk) begin
    if (rd_p || rd_s) rd_word <= mem[addr];
    if (rd_p)         pd_out  <= mem[addr];
    else if (st_p)    pd_out  <= sd_in;
    if (rd_s)         sd_out  <= mem[addr];
    else if (st_s)    sd_out  <= pd_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_oe     <= 1'b0;
      sd_oe     <= 1'b0;
      bad_combo <= 1'b0;
      rd_pend   <= 1'b0;
      par_ok    <= 1'b1;
    end else begin
      pd_oe     <= rd_p || st_p;
      sd_oe     <= rd_s || st_s;
      bad_combo <= bad;
      rd_pend   <= rd_p || rd_s;
      par_ok    <= (sel && rd_pend) ? ^rd_word : 1'b1;
    end
  end
endmodule

module cache_dsram_chk #(
  parameter int DATA_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_n,
  input logic            cs1_n,
  input logic            cs2,
  input logic            pie_n,
  input logic            sie_n,
  input logic            poe_n,
  input logic            soe_n,
  input logic [DATA_W:0] pd_in,
  input logic [DATA_W:0] sd_in,
  input logic [DATA_W:0] pd_out,
  input logic [DATA_W:0] sd_out,
  input logic            pd_oe,
  input logic            sd_oe,
  input logic            par_ok,
  input logic            bad_combo
);
  wire on = !cs1_n && cs2;

  // R1
  standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !on |=> !pd_oe && !sd_oe && par_ok);

  // R2
  proc_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (on && wr_n && pie_n && sie_n && !poe_n && soe_n) |=> pd_oe && !sd_oe && !bad_combo);

  // R3
  plain_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (on && !wr_n && !pie_n && sie_n && poe_n && soe_n) |=> !pd_oe && !sd_oe && !bad_combo);

  // R4
  write_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (on && !wr_n && !pie_n && sie_n && poe_n && !soe_n) |=> sd_oe && !pd_oe && sd_out == $past(pd_in));

  // R5
  inhibit_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (on && wr_n && pie_n && !sie_n && !poe_n && soe_n) |=> pd_oe && !sd_oe && pd_out == $past(sd_in));

  // R7
  both_in_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pie_n && !sie_n) |=> !pd_oe && !sd_oe);

  // R9
  contention_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_combo |-> !pd_oe && !sd_oe);
endmodule

bind cache_dsram cache_dsram_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_cache_dsram.sv
module tb_cache_dsram;
  localparam int AW = 11;
  localparam int DW = 8;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr = '0;
  logic wr_n = 1, cs1_n = 1, cs2 = 0, pie_n = 1, sie_n = 1, poe_n = 1, soe_n = 1;
  logic [DW:0] pd_in = '0, sd_in = '0;
  logic [DW:0] pd_out, sd_out;
  logic pd_oe, sd_oe, par_ok, bad_combo;

  int checks = 0, errors = 0;

  logic [DW:0] mdl [int];
  bit        pend = 0;
  logic [DW:0] pend_w = '0;
  bit        e_poe, e_soe, e_bad, e_par;
  logic [DW:0] e_pd, e_sd;
  string     tag;

  cache_dsram #(.ADDR_W(AW), .DATA_W(DW)) dut (.*);

  always #10 clk = ~clk;

  task automatic chk(bit good, string req, string what, int act, int exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic apply(bit cs, bit w, bit pi, bit si, bit po, bit so,
                       int a, logic [DW:0] pw, logic [DW:0] sw, string t);
    logic [DW:0] word;
    cs1_n = !cs; cs2 = cs; wr_n = w; pie_n = pi; sie_n = si; poe_n = po; soe_n = so;
    addr = a[AW-1:0]; pd_in = pw; sd_in = sw; tag = t;
    e_par = (cs && pend) ? ^pend_w : 1'b1;
    pend = 0;
    e_bad = cs && ((!pi && si && !po) || (!si && pi && !so));
    e_poe = 0; e_soe = 0;
    word = mdl.exists(a) ? mdl[a] : '0;
    if (cs && !e_bad) begin
      if (w && pi && si) begin
        if (!po) begin e_poe = 1; e_pd = word; end
        if (!so) begin e_soe = 1; e_sd = word; end
        if (!po || !so) begin pend = 1; pend_w = word; end
      end else if (!pi && si) begin
        if (!w) mdl[a] = pw;
        if (!so) begin e_soe = 1; e_sd = pw; end
      end else if (pi && !si) begin
        if (!w) mdl[a] = sw;
        if (!po) begin e_poe = 1; e_pd = sw; end
      end
    end
    @(negedge clk);
    chk(pd_oe == e_poe, tag, "pd_oe", pd_oe, e_poe);
    chk(sd_oe == e_soe, tag, "sd_oe", sd_oe, e_soe);
    if (e_poe) chk(pd_out == e_pd, tag, "pd_out", pd_out, e_pd);
    if (e_soe) chk(sd_out == e_sd, tag, "sd_out", sd_out, e_sd);
    chk(bad_combo == e_bad, "R9", "bad_combo", bad_combo, e_bad);
    chk(par_ok == e_par, "R8", "par_ok", par_ok, e_par);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(pd_oe == 0 && sd_oe == 0, "R10", "reset oe", {pd_oe, sd_oe}, 0);
    chk(par_ok == 1, "R10", "reset par_ok", par_ok, 1);
    chk(bad_combo == 0, "R10", "reset bad_combo", bad_combo, 0);
    rst_n = 1;
    @(negedge clk);
    // fill 0..15: even addresses from primary, odd from secondary (R3)
    for (int i = 0; i < 16; i++) begin
      if (i % 2 == 0) apply(1, 0, 0, 1, 1, 1, i, 9'(i * 37 + 1), 9'h0, "R3");
      else            apply(1, 0, 1, 0, 1, 1, i, 9'h0, 9'(i * 53 + 2), "R3");
    end
    apply(1, 0, 0, 1, 1, 1, 20, 9'h101, 9'h0, "R3");  // 2 ones: bad parity
    apply(1, 0, 0, 1, 1, 1, 21, 9'h007, 9'h0, "R3");  // 3 ones: good parity
    // R2 reads, R8 parity in following cycle, R10 timing
    apply(1, 1, 1, 1, 0, 1, 20, 0, 0, "R2");
    apply(1, 1, 1, 1, 1, 0, 21, 0, 0, "R2");
    apply(1, 1, 1, 1, 0, 0, 20, 0, 0, "R2");
    apply(1, 0, 0, 1, 1, 1, 22, 9'h0FF, 0, "R8");     // write after bad read
    apply(1, 1, 1, 1, 0, 0, 20, 0, 0, "R2");
    apply(0, 1, 1, 1, 0, 0, 20, 0, 0, "R1");          // deselect after read
    apply(1, 1, 1, 1, 1, 1, 20, 0, 0, "R2");
    // R4 write-through and allocate with stream
    apply(1, 0, 0, 1, 1, 0, 5, 9'h1A5, 0, "R4");
    apply(1, 0, 1, 0, 0, 1, 6, 0, 9'h05A, "R4");
    apply(1, 1, 1, 1, 0, 0, 5, 0, 0, "R4");
    apply(1, 1, 1, 1, 0, 0, 6, 0, 0, "R4");
    // R5 cache-inhibit streaming, array untouched
    apply(1, 1, 0, 1, 1, 0, 7, 9'h0F0, 0, "R5");
    apply(1, 1, 1, 0, 0, 1, 8, 0, 9'h133, "R5");
    apply(1, 1, 1, 1, 0, 0, 7, 0, 0, "R5");
    apply(1, 1, 1, 1, 0, 0, 8, 0, 0, "R5");
    // R6 no-ops, R7 ignored output enables
    apply(1, 0, 0, 0, 1, 1, 9, 9'h1FF, 9'h1FF, "R6");
    apply(1, 0, 1, 1, 0, 0, 9, 9'h1FF, 9'h1FF, "R6");
    apply(1, 1, 0, 0, 0, 0, 9, 9'h1FF, 9'h1FF, "R7");
    apply(1, 0, 0, 0, 0, 0, 9, 9'h1FF, 9'h1FF, "R7");
    apply(1, 1, 1, 1, 0, 0, 9, 0, 0, "R6");
    // R9 contention, no write
    apply(1, 0, 0, 1, 0, 1, 10, 9'h1EE, 0, "R9");
    apply(1, 0, 1, 0, 1, 0, 11, 0, 9'h1DD, "R9");
    apply(1, 1, 1, 1, 0, 0, 10, 0, 0, "R9");
    apply(1, 1, 1, 1, 0, 0, 11, 0, 0, "R9");
    // R1 deselected write is dropped
    apply(0, 0, 0, 1, 1, 1, 12, 9'h1BB, 0, "R1");
    apply(1, 1, 1, 1, 0, 1, 12, 0, 0, "R1");
    // mixed random traffic
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom;
      apply((r[2:0] != 0), r[3], r[4], r[5], r[6], r[7], int'(r[11:8]),
            9'($urandom), 9'($urandom), "R10");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule